// File: doc/BRIEF.md
# Gated Write-One-Clear Interrupt Controller

This block gathers single-cycle event pulses from up to 24 internal sources, arranged as three banks of eight. Every bank owns a pending-status register and an enable register, both reachable through a small parallel register port. The port has a bank select, a status/enable select, a write strobe, write data and combinational read data.

An event is recorded in its status bit only when the matching enable bit is already 1. A disabled source leaves no trace, so enabling it later does not raise an old event. Software retires pending bits by writing ones to the status register, one bit at a time or several at once. A single active-low interrupt line stays low while any pending bit in any bank is set.

Top module: `irq_wclr_ctrl`

## Requirements
- R1: After synchronous reset every status and enable register reads 0x00 and `irq_n_o` is high.
- R2: Bank select values 0, 1 and 2 address banks 0..2. Event bits [8k+7:8k] belong to bank k. `reg_kind_i`=0 selects status and 1 selects enable. A write to an enable register takes effect at the next clock edge, and the written value reads back unchanged.
- R3: An event pulse on a bit whose enable bit is 1 sets that status bit at the next clock edge.
- R4: An event pulse on a bit whose enable bit is 0 leaves the status bit at 0.
- R5: Writing 1 to a status bit clears it at the next clock edge.
- R6: Writing 0 to a status bit leaves that bit unchanged.
- R7: `irq_n_o` is low exactly while at least one status bit in any bank is 1. It is high once all status bits are 0.
- R8: If an enabled event and a write of 1 hit the same status bit in the same cycle, the bit ends up set.
- R9: Clearing an enable bit does not clear a status bit that is already pending.
- R10: The enable value used to gate an event is the one held before the edge. An event arriving in the same cycle as the write that enables its bit is not recorded.
- R11: Bank select value 3 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 24 | Event pulses, bank k on bits [8k+7:8k] |
| reg_bank_i | input | 2 | Register bank select |
| reg_kind_i | input | 1 | 0 = status register, 1 = enable register |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The in-RTL properties check the per-bit rules on every cycle:
- an enabled event always lands in its status bit (R3, R8);
- an unenabled event never sets a bit (R4);
- ones clear and zeros keep (R5, R6);
- an enable write neither disturbs pending bits nor loads a wrong value (R2, R9);
- an out-of-range bank write leaves every enable register stable (R11);
- the interrupt line can only return high after a status write (R7).

The reset state needs the bench's directed scenarios, as do the one-cycle delay before a new enable value gates events and the exact read-back values across banks.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 3;
    localparam int SEL_W     = 2;
    localparam int SRC_W     = BANK_W * NUM_BANKS;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_ENABLE = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic              we;
        logic [SEL_W-1:0]  bank;
        reg_kind_e         kind;
        logic [BANK_W-1:0] wdata;
    } host_req_t;

    function automatic logic bank_write(input host_req_t req, input int idx,
                                        input reg_kind_e kind);
        return req.we && (req.bank == SEL_W'(idx)) && (req.kind == kind);
    endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] evt,
    input  host_req_t         req,
    output logic [BANK_W-1:0] status,
    output logic [BANK_W-1:0] enable
);

    logic              wr_status;
    logic              wr_enable;
    logic [BANK_W-1:0] clr_mask;
    logic [BANK_W-1:0] capture;
    logic [BANK_W-1:0] status_nx;

    always_comb begin
        wr_status = bank_write(req, IDX, REG_STATUS);
        wr_enable = bank_write(req, IDX, REG_ENABLE);
        clr_mask  = wr_status ? req.wdata : '0;
        capture   = evt & enable;
        status_nx = (status & ~clr_mask) | capture;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= status_nx;
            if (wr_enable) enable <= req.wdata;
        end
    end

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_enable |=> (enable == $past(req.wdata))); // R2

    for (genvar b = 0; b < BANK_W; b++) begin : g_bit_chk
        AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
            (evt[b] && enable[b]) |=> status[b]); // R3
        AST_NO_GATED_SET: assert property (@(posedge clk) disable iff (rst)
            (!(evt[b] && enable[b]) && !status[b]) |=> !status[b]); // R4
        AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (wr_status && req.wdata[b] && !evt[b]) |=> !status[b]); // R5
        AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (wr_status && !req.wdata[b] && status[b]) |=> status[b]); // R6
        AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
            (wr_status && req.wdata[b] && evt[b] && enable[b]) |=> status[b]); // R8
        AST_EN_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
            (wr_enable && status[b]) |=> status[b]); // R9
    end

endmodule

// File: rtl/irq_rdmux.sv
module irq_rdmux
    import irq_pkg::*;
(
    input  logic [SRC_W-1:0]  status_all,
    input  logic [SRC_W-1:0]  enable_all,
    input  logic [SEL_W-1:0]  bank,
    input  reg_kind_e         kind,
    output logic [BANK_W-1:0] rdata
);

    logic [SRC_W-1:0] src;

    always_comb begin
        src   = (kind == REG_ENABLE) ? enable_all : status_all;
        rdata = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (bank == SEL_W'(k)) rdata = src[k*BANK_W +: BANK_W];
        end
    end

endmodule

// File: rtl/irq_outgen.sv
module irq_outgen
    import irq_pkg::*;
(
    input  logic [SRC_W-1:0] status_all,
    output logic             irq_n
);

    always_comb irq_n = ~(|status_all);

endmodule

// File: rtl/irq_wclr_ctrl.sv
module irq_wclr_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  evt_i,
    input  logic [SEL_W-1:0]  reg_bank_i,
    input  logic              reg_kind_i,
    input  logic              reg_we_i,
    input  logic [BANK_W-1:0] reg_wdata_i,
    output logic [BANK_W-1:0] reg_rdata_o,
    output logic              irq_n_o
);

    host_req_t        req;
    logic [SRC_W-1:0] status_all;
    logic [SRC_W-1:0] enable_all;

    always_comb begin
        req.we    = reg_we_i;
        req.bank  = reg_bank_i;
        req.kind  = reg_kind_e'(reg_kind_i);
        req.wdata = reg_wdata_i;
    end

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        irq_bank #(.IDX(k)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .evt    (evt_i[k*BANK_W +: BANK_W]),
            .req    (req),
            .status (status_all[k*BANK_W +: BANK_W]),
            .enable (enable_all[k*BANK_W +: BANK_W])
        );
    end

    irq_rdmux u_rdmux (
        .status_all (status_all),
        .enable_all (enable_all),
        .bank       (reg_bank_i),
        .kind       (req.kind),
        .rdata      (reg_rdata_o)
    );

    irq_outgen u_outgen (
        .status_all (status_all),
        .irq_n      (irq_n_o)
    );

    AST_IRQ_RELEASE_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n_o) |-> $past(reg_we_i && reg_kind_i == 1'b0)); // R7

    AST_OOR_BANK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && reg_bank_i >= SEL_W'(NUM_BANKS)) |=> $stable(enable_all)); // R11

endmodule

// File: tb/sim_irq_wclr_ctrl.sv
module sim_irq_wclr_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] evt_i;
    logic [1:0]  reg_bank_i;
    logic        reg_kind_i;
    logic        reg_we_i;
    logic [7:0]  reg_wdata_i;
    logic [7:0]  reg_rdata_o;
    logic        irq_n_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_wclr_ctrl u0 (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt_i),
        .reg_bank_i  (reg_bank_i),
        .reg_kind_i  (reg_kind_i),
        .reg_we_i    (reg_we_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_n_o     (irq_n_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int bank, input bit kind, input int exp, input string req);
        reg_bank_i = 2'(bank);
        reg_kind_i = kind;
        #1;
        chk(req, int'(reg_rdata_o), exp);
    endtask

    task automatic wr(input int bank, input bit kind, input int data);
        reg_bank_i  = 2'(bank);
        reg_kind_i  = kind;
        reg_wdata_i = 8'(data);
        reg_we_i    = 1'b1;
        tick();
        reg_we_i    = 1'b0;
    endtask

    task automatic pulse(input logic [23:0] v);
        evt_i = v;
        tick();
        evt_i = '0;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            rd(k, 1'b0, 0, "R1 status");
            rd(k, 1'b1, 0, "R1 enable");
        end
        chk("R1 irq_n", int'(irq_n_o), 1);
    endtask

    task automatic t_enable_rw();
        wr(0, 1'b1, 8'hA5);
        wr(1, 1'b1, 8'h3C);
        wr(2, 1'b1, 8'hFF);
        rd(0, 1'b1, 8'hA5, "R2 en0");
        rd(1, 1'b1, 8'h3C, "R2 en1");
        rd(2, 1'b1, 8'hFF, "R2 en2");
        wr(3, 1'b1, 8'h00);
        rd(0, 1'b1, 8'hA5, "R11 en0 kept");
        rd(1, 1'b1, 8'h3C, "R11 en1 kept");
        rd(2, 1'b1, 8'hFF, "R11 en2 kept");
        rd(3, 1'b1, 0, "R11 en3 reads zero");
        rd(3, 1'b0, 0, "R11 st3 reads zero");
    endtask

    task automatic t_gate();
        wr(0, 1'b1, 8'h0F);
        wr(1, 1'b1, 8'hFF);
        wr(2, 1'b1, 8'h00);
        chk("R7 idle irq_n", int'(irq_n_o), 1);
        pulse(24'hFFFFFF);
        rd(0, 1'b0, 8'h0F, "R3/R4 st0 partial");
        rd(1, 1'b0, 8'hFF, "R3 st1 all");
        rd(2, 1'b0, 8'h00, "R4 st2 none");
        chk("R7 irq_n low", int'(irq_n_o), 0);
    endtask

    task automatic t_w1c();
        wr(0, 1'b0, 8'h00);
        rd(0, 1'b0, 8'h0F, "R6 zero write");
        wr(1, 1'b0, 8'h0F);
        rd(1, 1'b0, 8'hF0, "R5 partial clear");
        wr(0, 1'b0, 8'h0F);
        rd(0, 1'b0, 8'h00, "R5 st0 cleared");
        chk("R7 still pending", int'(irq_n_o), 0);
        wr(1, 1'b0, 8'hF0);
        rd(1, 1'b0, 8'h00, "R5 st1 cleared");
        chk("R7 released", int'(irq_n_o), 1);
    endtask

    task automatic t_set_wins();
        pulse(24'h008100);
        rd(1, 1'b0, 8'h81, "R3 two bits");
        evt_i = 24'h000100;
        wr(1, 1'b0, 8'h81);
        evt_i = '0;
        rd(1, 1'b0, 8'h01, "R8 set beats clear");
        wr(1, 1'b0, 8'h01);
        rd(1, 1'b0, 8'h00, "R5 cleanup");
    endtask

    task automatic t_en_clear();
        pulse(24'h000800);
        wr(1, 1'b1, 8'h00);
        rd(1, 1'b0, 8'h08, "R9 pending kept");
        chk("R9 irq_n low", int'(irq_n_o), 0);
        pulse(24'h00FF00);
        rd(1, 1'b0, 8'h08, "R4 after disable");
        wr(1, 1'b0, 8'h08);
        chk("R7 released again", int'(irq_n_o), 1);
    endtask

    task automatic t_en_timing();
        evt_i = 24'h010000;
        wr(2, 1'b1, 8'h01);
        evt_i = '0;
        rd(2, 1'b0, 8'h00, "R10 same-cycle enable");
        pulse(24'h010000);
        rd(2, 1'b0, 8'h01, "R10 next event");
        wr(3, 1'b0, 8'hFF);
        rd(2, 1'b0, 8'h01, "R11 st2 kept");
        chk("R11 irq_n low", int'(irq_n_o), 0);
        wr(2, 1'b0, 8'h01);
        rd(2, 1'b0, 8'h00, "R5 st2 cleared");
    endtask

    initial begin
        rst = 1'b1;
        evt_i = '0;
        reg_bank_i = '0;
        reg_kind_i = 1'b0;
        reg_we_i = 1'b0;
        reg_wdata_i = '0;
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_enable_rw();
        t_gate();
        t_w1c();
        t_set_wins();
        t_en_clear();
        t_en_timing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule